// File: doc/BRIEF.md
# Early-Terminating Iterative Integer Divider

This block is the division engine of a multiply/divide unit. A one-cycle start pulse hands it a dividend, a divisor and a signed/unsigned selector. It then works through the dividend one bit per cycle with a restoring shift-subtract step. The quotient goes to the low result register and the remainder to the high result register, where a later move-from-result operation reads them.

Before the bit loop starts, the block measures the dividend's magnitude in 8-bit groups. It skips the leading groups that are all zero, so small dividends finish early. Signed operands are divided as magnitudes. One extra cycle then corrects the signs: the quotient is negated when the operand signs differ, and the remainder takes the dividend's sign.

The controller has four states:
- `ST_IDLE` waits for work. On a start pulse (the "accept" transition) it moves to `ST_PREP`.
- `ST_PREP` classifies the operands and loads the loop. The "load" transition always leads to `ST_ITER`.
- `ST_ITER` performs one quotient bit per cycle. On its last step, the "finish-unsigned" transition returns to `ST_IDLE` and publishes the result. For signed work, the "finish-signed" transition moves to `ST_FIX` instead.
- `ST_FIX` applies the sign correction. The "publish" transition returns it to `ST_IDLE`.

Top module: `itdiv_unit`

## Requirements
- R1: Unsigned division puts the quotient floor(a/b) on `lo_out` and the remainder a mod b on `hi_out`.
- R2: Let the start pulse be sampled at edge k. For unsigned work, `done` is high in the cycle after edge k+L. L is 9, 17, 25 or 33 when the dividend is below 2^8, 2^16, 2^24 or 2^32 respectively. A zero dividend counts as the 8-bit class.
- R3: Signed division (`is_signed`=1) divides the two's-complement magnitudes. The quotient is negated when exactly one operand is negative. The remainder is negated when the dividend is negative. This matches division truncated toward zero.
- R4: For signed work, L is one cycle more than in R2: 10, 18, 26 or 34. The width class is taken from the dividend's absolute value.
- R5: `busy` is high from the cycle after the accepted start up to the cycle before `done`. `done` is a one-cycle pulse during which `busy` is low. `busy` and `done` are never high together.
- R6: A start pulse that arrives while `busy` is high is ignored. The running division's result and latency are unchanged.
- R7: A zero divisor sets `div_zero` together with `done`. In that case `lo_out` is all ones, `hi_out` equals the dividend as given, and the latency of R2/R4 still applies. When the divisor is nonzero, `div_zero` is low with `done`.
- R8: Signed 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0, with no flag.
- R9: `lo_out`, `hi_out` and `div_zero` change only in a `done` cycle and hold their values between results.
- R10: After reset, `busy`, `done`, `div_zero`, `lo_out` and `hi_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (taken only when not busy) |
| is_signed | input | 1 | 1 = two's-complement operands |
| dividend | input | 32 | Dividend operand |
| divisor | input | 32 | Divisor operand |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result-ready pulse |
| div_zero | output | 1 | Last result had a zero divisor |
| lo_out | output | 32 | Quotient result register |
| hi_out | output | 32 | Remainder result register |

## Verification
The bench works out each result's due cycle before it checks anything. For each operation it computes L from the dividend's magnitude class and the signed flag. It then counts falling edges from the accepting edge. It expects `done` at exactly count L, with `busy` high at every earlier count. The quotient, remainder and flag are compared in that same `done` cycle. Hold behaviour is checked several cycles later with `start` low. Start pulses injected two cycles into a running operation must leave both the due cycle and the values unchanged.

// File: rtl/itdiv_pkg.sv
package itdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_ITER = 2'd2,
        ST_FIX  = 2'd3
    } itdiv_state_e;
endpackage

// File: rtl/itdiv_classify.sv
// Absolute value of an operand and the number of GROUP-bit groups
// needed to hold it (at least one).
module itdiv_classify #(
    parameter int WIDTH = 32,
    parameter int GROUP = 8,
    localparam int NGRP = WIDTH / GROUP,
    localparam int GW   = $clog2(NGRP + 1)
) (
    input  logic [WIDTH-1:0] value,
    input  logic             is_signed,
    output logic [WIDTH-1:0] mag,
    output logic [GW-1:0]    groups
);
    logic negative;

    always_comb begin
        negative = is_signed & value[WIDTH-1];
        mag      = negative ? (~value + 1'b1) : value;
        groups   = GW'(1);
        for (int g = 1; g < NGRP; g++) begin
            if ((mag >> (g * GROUP)) != '0) groups = GW'(g + 1);
        end
    end
endmodule

// File: rtl/itdiv_step.sv
// One restoring shift-subtract step.
module itdiv_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem,
    input  logic             bit_in,
    input  logic [WIDTH-1:0] den,
    output logic [WIDTH-1:0] rem_next,
    output logic             q_bit
);
    logic [WIDTH:0] trial;
    logic [WIDTH:0] diff;

    always_comb begin
        trial = {rem, bit_in};
        diff  = trial - {1'b0, den};
        if (trial >= {1'b0, den}) begin
            q_bit    = 1'b1;
            rem_next = diff[WIDTH-1:0];
        end else begin
            q_bit    = 1'b0;
            rem_next = trial[WIDTH-1:0];
        end
    end
endmodule

// File: rtl/itdiv_unit.sv
module itdiv_unit #(
    parameter int WIDTH = 32,
    parameter int GROUP = 8,
    localparam int NGRP = WIDTH / GROUP,
    localparam int GW   = $clog2(NGRP + 1),
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_signed,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic             div_zero,
    output logic [WIDTH-1:0] lo_out,
    output logic [WIDTH-1:0] hi_out
);
    import itdiv_pkg::*;

    itdiv_state_e state_q, state_d;

    logic [WIDTH-1:0] a_q, b_q, dmag_q, rem_q, qsh_q;
    logic             sgn_q, negq_q, negr_q, zero_q;
    logic [CW-1:0]    cnt_q;

    logic [WIDTH-1:0] a_mag, b_mag, rem_nxt, q_fin;
    logic [GW-1:0]    a_grp;
    logic             q_bit, last_step;
    logic [CW-1:0]    steps, shamt;

    itdiv_classify #(.WIDTH(WIDTH), .GROUP(GROUP)) u_class (
        .value     (a_q),
        .is_signed (sgn_q),
        .mag       (a_mag),
        .groups    (a_grp)
    );

    itdiv_step #(.WIDTH(WIDTH)) u_step (
        .rem      (rem_q),
        .bit_in   (qsh_q[WIDTH-1]),
        .den      (dmag_q),
        .rem_next (rem_nxt),
        .q_bit    (q_bit)
    );

    always_comb begin
        b_mag     = (sgn_q & b_q[WIDTH-1]) ? (~b_q + 1'b1) : b_q;
        steps     = CW'(GROUP) * CW'(a_grp);
        shamt     = CW'(WIDTH) - steps;
        last_step = (cnt_q == CW'(1));
        q_fin     = {qsh_q[WIDTH-2:0], q_bit};
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_PREP;
            ST_PREP: state_d = ST_ITER;
            ST_ITER: if (last_step) state_d = sgn_q ? ST_FIX : ST_IDLE;
            ST_FIX:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            dmag_q   <= '0;
            rem_q    <= '0;
            qsh_q    <= '0;
            cnt_q    <= '0;
            sgn_q    <= 1'b0;
            negq_q   <= 1'b0;
            negr_q   <= 1'b0;
            zero_q   <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            div_zero <= 1'b0;
            lo_out   <= '0;
            hi_out   <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        a_q   <= dividend;
                        b_q   <= divisor;
                        sgn_q <= is_signed;
                        busy  <= 1'b1;
                    end
                end
                ST_PREP: begin
                    rem_q  <= '0;
                    qsh_q  <= a_mag << shamt;
                    cnt_q  <= steps;
                    dmag_q <= b_mag;
                    zero_q <= (b_q == '0);
                    negq_q <= sgn_q & (a_q[WIDTH-1] ^ b_q[WIDTH-1]);
                    negr_q <= sgn_q & a_q[WIDTH-1];
                end
                ST_ITER: begin
                    rem_q <= rem_nxt;
                    qsh_q <= q_fin;
                    cnt_q <= cnt_q - CW'(1);
                    if (last_step && !sgn_q) begin
                        lo_out   <= zero_q ? '1 : q_fin;
                        hi_out   <= zero_q ? a_q : rem_nxt;
                        div_zero <= zero_q;
                        done     <= 1'b1;
                        busy     <= 1'b0;
                    end
                end
                ST_FIX: begin
                    lo_out   <= zero_q ? '1 : (negq_q ? (~qsh_q + 1'b1) : qsh_q);
                    hi_out   <= zero_q ? a_q : (negr_q ? (~rem_q + 1'b1) : rem_q);
                    div_zero <= zero_q;
                    done     <= 1'b1;
                    busy     <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/itdiv_unit_chk.sv
module itdiv_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             div_zero,
    input logic [WIDTH-1:0] lo_out,
    input logic [WIDTH-1:0] hi_out
);
    logic [7:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 age <= '0;
        else if (start && !busy)    age <= '0;
        else if (busy && age != 8'hFF) age <= age + 8'd1;
    end

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r5_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r6_no_drop_midway: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R2 and R4: the latency must be one of the eight allowed values
    a_r2_latency_class: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (age == 8'd9  || age == 8'd10 || age == 8'd17 || age == 8'd18 ||
                  age == 8'd25 || age == 8'd26 || age == 8'd33 || age == 8'd34));

    a_r7_zero_quot: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> (lo_out == '1));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(lo_out) && $stable(hi_out) && $stable(div_zero)));
endmodule

bind itdiv_unit itdiv_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .div_zero (div_zero),
    .lo_out   (lo_out),
    .hi_out   (hi_out)
);

// File: tb/itdiv_unit_tb.sv
module itdiv_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic [31:0] dividend = '0;
    logic [31:0] divisor = '0;
    logic        busy, done, div_zero;
    logic [31:0] lo_out, hi_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    itdiv_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_signed (is_signed),
        .dividend  (dividend),
        .divisor   (divisor),
        .busy      (busy),
        .done      (done),
        .div_zero  (div_zero),
        .lo_out    (lo_out),
        .hi_out    (hi_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input bit inject, input bit hold);
        logic [31:0] eq, er, mag;
        logic        ez;
        int          el, lat, g;
        bit          busy_ok;
        string       tq, tl;
        ez  = (b == 32'd0);
        mag = (s && a[31]) ? (~a + 32'd1) : a;
        g   = (mag < 32'h100) ? 1 : (mag < 32'h10000) ? 2 : (mag < 32'h1000000) ? 3 : 4;
        el  = 8 * g + 1 + (s ? 1 : 0);
        if (ez) begin
            eq = 32'hFFFF_FFFF; er = a;
        end else if (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            eq = 32'h8000_0000; er = 32'd0;
        end else if (s) begin
            eq = $signed(a) / $signed(b); er = $signed(a) % $signed(b);
        end else begin
            eq = a / b; er = a % b;
        end
        tq = ez ? "R7" : (s && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) ? "R8" :
             (inject ? "R6" : (s ? "R3" : "R1"));
        tl = inject ? "R6" : (s ? "R4" : "R2");

        @(negedge clk);
        start = 1'b1; dividend = a; divisor = b; is_signed = s;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0; busy_ok = 1'b1;
        while (!done && lat < 80) begin
            if (!busy) busy_ok = 1'b0;
            if (inject && lat == 2) begin
                start = 1'b1; dividend = ~a; divisor = b + 32'd3; is_signed = ~s;
            end else if (inject && lat == 3) begin
                start = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        chk(tl, 64'(lat), 64'(el));
        chk("R5", {62'd0, busy_ok, busy}, {62'd0, 1'b1, 1'b0});
        chk(tq, {lo_out, hi_out}, {eq, er});
        chk("R7", 64'(div_zero), 64'(ez));
        if (hold) begin
            repeat (4) @(negedge clk);
            chk("R9", {lo_out, hi_out}, {eq, er});
            chk("R9", {62'd0, done, div_zero}, {62'd0, 1'b0, ez});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] avals [12];
        logic [31:0] bvals [9];
        logic [31:0] lfsr;
        int          k;
        avals = '{32'd0, 32'd1, 32'd255, 32'd256, 32'd65535, 32'd65536,
                  32'h00FF_FFFF, 32'h0100_0000, 32'hFFFF_FFFF, 32'h8000_0000,
                  32'hFFFF_FF00, 32'h1234_5678};
        bvals = '{32'd1, 32'd2, 32'd3, 32'd7, 32'd255, 32'h0001_0000,
                  32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd0};

        repeat (3) @(negedge clk);
        chk("R10", {60'd0, busy, done, div_zero, 1'b0}, 64'd0);
        chk("R10", {lo_out, hi_out}, 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", {61'd0, busy, done, div_zero}, 64'd0);

        run(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1);   // R8
        run(32'd100, 32'd0, 1'b0, 1'b0, 1'b1);                  // R7 unsigned
        run(32'hFFFF_FF9C, 32'd0, 1'b1, 1'b0, 1'b1);            // R7 signed
        run(32'hFFFF_FFF9, 32'd2, 1'b1, 1'b1, 1'b1);            // R6 with R3

        k = 0;
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 12; i++) begin
                for (int j = 0; j < 9; j++) begin
                    run(avals[i], bvals[j], s[0], (k % 5) == 0, (k % 17) == 0);
                    k++;
                end
            end
        end

        lfsr = 32'hACE1_2468;
        for (int n = 0; n < 160; n++) begin
            logic [31:0] a, b;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr >> (8 * (n % 4));
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            b = lfsr >> (n % 29);
            run(a, b, n[0], (n % 7) == 3, 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule